// File: doc/BRIEF.md
# Microprogram Sequencer with Control Store

This block is the address-selection half of a microprogrammed control unit, packaged with its own read-only control store. A control address register selects one word of the store. The word's three micro-operation fields go straight to an external datapath. The word's condition, branch-type and target fields decide which word is selected on the next clock edge.

The next address can come from one of four places: the following word, the branch target in the word, a one-entry subroutine return register, or an entry point derived from a 4-bit machine opcode. The control store contents are computed at elaboration from a fixed formula, so no file is read. The store is read combinationally, so the fields on the outputs always belong to the address shown on `ctl_addr`. A step enable freezes the whole sequencer when it is low.

Top module: `useq_top`

## Requirements
- R1: While `rst_n` is low, `ctl_addr` is 0 and the subroutine return register is 0. Leaving reset therefore starts execution at word 0.
- R2: The word at address a (7 bits) is computed as follows:
  - first field = a[2:0]
  - second field = a[5:3]
  - third field = ~a[2:0]
  - condition select = a[4:3]
  - branch type = a[1:0] XOR a[6:5]
  - target = (37·a + 11) mod 128

  `uop_a`, `uop_b` and `uop_c` show the three fields of the word at `ctl_addr` in the same cycle.
- R3: A 20-bit word is packed with the first field at bits 19:17, the second at 16:14, the third at 13:11, the condition select at 10:9, the branch type at 8:7 and the target at 6:0.
- R4: The condition select picks the tested condition: 0 is always true, 1 is `st_sign`, 2 is `st_zero` and 3 is `st_ind`. When branch type is 0 or 1 and the tested condition is false, the next address is `ctl_addr`+1.
- R5: Branch type 0 with a true condition loads the target into `ctl_addr`.
- R6: Branch type 1 with a true condition loads the target into `ctl_addr` and stores `ctl_addr`+1 in the return register. With a false condition, the return register is left unchanged.
- R7: Branch type 2 loads the return register into `ctl_addr`, whatever the condition.
- R8: Branch type 3 loads {0, `opcode`[3:0], 2'b00} into `ctl_addr`.
- R9: While `step_en` is low, `ctl_addr` and the return register keep their values.
- R10: The sequential successor of address 127 is address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | Advances the sequencer when high |
| st_sign | input | 1 | Sign status, tested by condition select 1 |
| st_zero | input | 1 | Zero status, tested by condition select 2 |
| st_ind | input | 1 | Indirect status, tested by condition select 3 |
| opcode | input | 4 | Machine opcode used by the mapping branch |
| uop_a | output | 3 | First micro-operation field of the current word |
| uop_b | output | 3 | Second micro-operation field of the current word |
| uop_c | output | 3 | Third micro-operation field of the current word |
| ctl_addr | output | 7 | Current control address |

## Verification
The condition test and the return-register save fall in the same cycle on every branch-type-1 word. The save must follow the tested status bit exactly: it happens when the bit is true and does not happen when it is false.

The bench drives random status bits and opcodes on every cycle while a model walks the same program. A call that is not taken is therefore often followed, some steps later, by a return. That return exposes whether the return register was wrongly overwritten. A stalled step (`step_en` low) landing on a call word is judged the same way.

// File: rtl/useq_pkg.sv
package useq_pkg;
   localparam int FLD_W = 3;
   localparam int SEL_W = 2;

   typedef enum logic [SEL_W-1:0] {
      BR_JUMP = 2'd0,
      BR_CALL = 2'd1,
      BR_RET  = 2'd2,
      BR_MAP  = 2'd3
   } br_kind_e;

   typedef enum logic [SEL_W-1:0] {
      CD_TRUE = 2'd0,
      CD_SIGN = 2'd1,
      CD_ZERO = 2'd2,
      CD_IND  = 2'd3
   } cond_sel_e;
endpackage

// File: rtl/useq_ctrl_store.sv
module useq_ctrl_store
   import useq_pkg::*;
#(
   parameter int AW = 7
) (
   input  logic [AW-1:0]             addr,
   output logic [3*FLD_W+2*SEL_W+AW-1:0] word
);
   localparam int DEPTH = 1 << AW;
   localparam int DW    = 3*FLD_W + 2*SEL_W + AW;
   localparam int MUL   = 37;
   localparam int OFS   = 11;

   if (AW < 6) begin : g_bad_aw
      $error("useq_ctrl_store: AW must be at least 6");
   end

   logic [DW-1:0] rom [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      localparam logic [AW-1:0] A   = AW'(i);
      localparam logic [AW-1:0] TGT = AW'((MUL * i + OFS) % DEPTH);
      assign rom[i] = {A[2:0], A[5:3], ~A[2:0], A[4:3],
                       A[1:0] ^ A[AW-1:AW-2], TGT};
   end

   assign word = rom[addr];
endmodule

// File: rtl/useq_cond_sel.sv
module useq_cond_sel
   import useq_pkg::*;
(
   input  cond_sel_e sel,
   input  logic      st_sign,
   input  logic      st_zero,
   input  logic      st_ind,
   output logic      hit
);
   always_comb begin
      unique case (sel)
         CD_TRUE: hit = 1'b1;
         CD_SIGN: hit = st_sign;
         CD_ZERO: hit = st_zero;
         default: hit = st_ind;
      endcase
   end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
   import useq_pkg::*;
#(
   parameter int AW  = 7,
   parameter int OPW = 4
) (
   input  logic [AW-1:0]  car,
   input  logic [AW-1:0]  target,
   input  logic [AW-1:0]  ret_addr,
   input  logic [OPW-1:0] opcode,
   input  br_kind_e       kind,
   input  logic           hit,
   output logic [AW-1:0]  nxt,
   output logic [AW-1:0]  seq,
   output logic           save_en
);
   localparam int MAP_LSB = 2;

   if (AW < OPW + MAP_LSB) begin : g_bad_map
      $error("useq_next_addr: AW too small for opcode map");
   end

   logic [AW-1:0] map_addr;

   assign seq      = car + 1'b1;
   assign map_addr = AW'({opcode, {MAP_LSB{1'b0}}});

   always_comb begin
      save_en = 1'b0;
      unique case (kind)
         BR_JUMP: nxt = hit ? target : seq;
         BR_CALL: begin
            nxt     = hit ? target : seq;
            save_en = hit;
         end
         BR_RET:  nxt = ret_addr;
         default: nxt = map_addr;
      endcase
   end
endmodule

// File: rtl/useq_top.sv
module useq_top
   import useq_pkg::*;
#(
   parameter int AW  = 7,
   parameter int OPW = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_en,
   input  logic             st_sign,
   input  logic             st_zero,
   input  logic             st_ind,
   input  logic [OPW-1:0]   opcode,
   output logic [FLD_W-1:0] uop_a,
   output logic [FLD_W-1:0] uop_b,
   output logic [FLD_W-1:0] uop_c,
   output logic [AW-1:0]    ctl_addr
);
   localparam int DW     = 3*FLD_W + 2*SEL_W + AW;
   localparam int BR_LSB = AW;
   localparam int CD_LSB = AW + SEL_W;
   localparam int C_LSB  = AW + 2*SEL_W;
   localparam int B_LSB  = C_LSB + FLD_W;
   localparam int A_LSB  = B_LSB + FLD_W;

   logic [DW-1:0]  word;
   logic [AW-1:0]  car_q, sbr_q, nxt, seq, ad_f;
   br_kind_e       br_f;
   cond_sel_e      cd_f;
   logic           hit, save_en;

   useq_ctrl_store #(.AW(AW)) u_store (
      .addr (car_q),
      .word (word)
   );

   assign uop_a = word[A_LSB +: FLD_W];
   assign uop_b = word[B_LSB +: FLD_W];
   assign uop_c = word[C_LSB +: FLD_W];
   assign cd_f  = cond_sel_e'(word[CD_LSB +: SEL_W]);
   assign br_f  = br_kind_e'(word[BR_LSB +: SEL_W]);
   assign ad_f  = word[AW-1:0];

   useq_cond_sel u_cond (
      .sel     (cd_f),
      .st_sign (st_sign),
      .st_zero (st_zero),
      .st_ind  (st_ind),
      .hit     (hit)
   );

   useq_next_addr #(.AW(AW), .OPW(OPW)) u_next (
      .car      (car_q),
      .target   (ad_f),
      .ret_addr (sbr_q),
      .opcode   (opcode),
      .kind     (br_f),
      .hit      (hit),
      .nxt      (nxt),
      .seq      (seq),
      .save_en  (save_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         car_q <= '0;
         sbr_q <= '0;
      end else if (step_en) begin
         car_q <= nxt;
         if (save_en) sbr_q <= seq;
      end
   end

   assign ctl_addr = car_q;
endmodule

// File: rtl/useq_checker.sv
module useq_checker #(
   parameter int AW  = 7,
   parameter int OPW = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           step_en,
   input logic           st_sign,
   input logic           st_zero,
   input logic           st_ind,
   input logic [OPW-1:0] opcode,
   input logic [AW-1:0]  ctl_addr,
   input logic [1:0]     br_f,
   input logic [1:0]     cd_f,
   input logic [AW-1:0]  ad_f,
   input logic [AW-1:0]  sbr_q
);
   logic          cond;
   logic [AW-1:0] succ;
   logic [AW-1:0] map_v;

   always_comb begin
      case (cd_f)
         2'd0:    cond = 1'b1;
         2'd1:    cond = st_sign;
         2'd2:    cond = st_zero;
         default: cond = st_ind;
      endcase
   end
   assign succ  = ctl_addr + 1'b1;
   assign map_v = AW'({opcode, 2'b00});

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> ($stable(ctl_addr) && $stable(sbr_q)));

   assert_jump_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && br_f == 2'd0 && cond) |=> ctl_addr == $past(ad_f));

   assert_fallthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && br_f <= 2'd1 && !cond) |=> ctl_addr == $past(succ));

   assert_call_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && br_f == 2'd1 && cond) |=>
         (ctl_addr == $past(ad_f) && sbr_q == $past(succ)));

   assert_keep_ret_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(step_en && br_f == 2'd1 && cond) |=> $stable(sbr_q));

   assert_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && br_f == 2'd2) |=> ctl_addr == $past(sbr_q));

   assert_map_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && br_f == 2'd3) |=> ctl_addr == $past(map_v));
endmodule

bind useq_top useq_checker #(.AW(AW), .OPW(OPW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .step_en  (step_en),
   .st_sign  (st_sign),
   .st_zero  (st_zero),
   .st_ind   (st_ind),
   .opcode   (opcode),
   .ctl_addr (ctl_addr),
   .br_f     (br_f),
   .cd_f     (cd_f),
   .ad_f     (ad_f),
   .sbr_q    (sbr_q)
);

// File: tb/sim_useq_top.sv
`timescale 1ns/1ps
module sim_useq_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       step_en = 1'b0;
   logic       st_sign = 1'b0;
   logic       st_zero = 1'b0;
   logic       st_ind = 1'b0;
   logic [3:0] opcode = 4'd0;
   logic [2:0] uop_a, uop_b, uop_c;
   logic [6:0] ctl_addr;

   int n_chk = 0;
   int n_bad = 0;
   int wraps = 0;
   bit done = 0;

   always #5 clk = ~clk;

   useq_top u0 (
      .clk(clk), .rst_n(rst_n), .step_en(step_en),
      .st_sign(st_sign), .st_zero(st_zero), .st_ind(st_ind),
      .opcode(opcode), .uop_a(uop_a), .uop_b(uop_b), .uop_c(uop_c),
      .ctl_addr(ctl_addr)
   );

   // Word of R2, packed as R3: F1 19:17, F2 16:14, F3 13:11, CD 10:9, BR 8:7, AD 6:0
   function automatic logic [19:0] ref_word(logic [6:0] a);
      logic [6:0] tgt;
      tgt = 7'((37 * int'(a) + 11) % 128);
      return {a[2:0], a[5:3], ~a[2:0], a[4:3], a[1:0] ^ a[6:5], tgt};
   endfunction

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic check_outputs(string tag, logic [6:0] exp_car);
      logic [19:0] w;
      w = ref_word(exp_car);
      check(tag, int'(ctl_addr), int'(exp_car));
      check("R2 R3 fields", int'({uop_a, uop_b, uop_c}), int'(w[19:11]));
   endtask

   initial begin
      logic [6:0] exp_car = 7'd0;
      logic [6:0] exp_sbr = 7'd0;
      string tag = "R1";
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_outputs("R1 reset", 7'd0);
      rst_n = 1'b1;
      for (int it = 0; it < 40000; it++) begin
         logic [19:0] w;
         logic        hit;
         logic [1:0]  cd, br;
         logic [6:0]  succ;
         check_outputs(tag, exp_car);
         if (it % 3000 == 2999) begin
            rst_n = 1'b0;
            #1;
            check_outputs("R1 reset", 7'd0);
            exp_car = 0;
            exp_sbr = 0;
            @(negedge clk);
            rst_n = 1'b1;
            tag = "R1";
            check_outputs(tag, exp_car);
         end
         step_en = ($urandom % 6) != 0;
         st_sign = 1'($urandom);
         st_zero = 1'($urandom);
         st_ind  = 1'($urandom);
         opcode  = 4'($urandom);
         w    = ref_word(exp_car);
         cd   = w[10:9];
         br   = w[8:7];
         succ = exp_car + 7'd1;
         case (cd)
            2'd0: hit = 1'b1;
            2'd1: hit = st_sign;
            2'd2: hit = st_zero;
            default: hit = st_ind;
         endcase
         if (!step_en) begin
            tag = "R9 hold";
         end else if (br == 2'd3) begin
            tag = "R8 map";
            exp_car = {1'b0, opcode, 2'b00};
         end else if (br == 2'd2) begin
            tag = "R7 return";
            exp_car = exp_sbr;
         end else if (hit) begin
            tag = (br == 2'd1) ? "R6 call" : "R5 jump";
            if (br == 2'd1) exp_sbr = succ;
            exp_car = w[6:0];
         end else begin
            tag = (exp_car == 7'd127) ? "R10 wrap" : "R4 not taken";
            if (exp_car == 7'd127) wraps++;
            exp_car = succ;
         end
         @(negedge clk);
      end
      $display("info: %0d sequential wraps seen", wraps);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule